// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of shared tokens that two independent ports, called left and right, use to claim and hand back shared resources without any software locking. Each port reaches the bank by raising its semaphore select while its memory enable is low, picks a token with the low bits of its address, and writes data bit 0: a 0 asks for the token, a 1 gives it back or withdraws an outstanding request. A read returns the token as the reading port sees it: 0 when that port owns it, 1 otherwise, copied onto every bit of the read bus.

Every token is a five-state machine. The states are FREE (nobody holds it), LEFT_OWN and RIGHT_OWN (one side holds it, no waiter), LEFT_OWN_RWAIT (left holds, right waits) and RIGHT_OWN_LWAIT (right holds, left waits). The transitions are: claim (FREE to a single-owner state), tie (FREE to LEFT_OWN_RWAIT when both ask in one cycle), queue (single-owner to the matching waiting state when the other side asks), release (single-owner to FREE), handoff (waiting state to the other side's single-owner state when the holder releases), withdraw (waiting state back to the single-owner state when the waiter writes 1) and the combined release-and-withdraw (waiting state to FREE). Any other write leaves the state where it is.

Reads go through a per-port output register. It changes only at the clock edge that ends a legal read and then holds, so a write from the opposite port cannot disturb a value that has already been read.

Top module: `sem_bank`

## Requirements
- R1: After reset all tokens are FREE, and both read registers hold all ones.
- R2: The token index is the low 3 address bits; higher address bits have no effect on which token is touched.
- R3: An access counts only when semaphore select is 1 and memory enable is 0; a read or write with both set changes neither token state nor the read register.
- R4: A write looks at data bit 0 only: 0 requests the token, 1 releases it or withdraws a pending request; other data bits are ignored.
- R5: When a FREE token is requested by one side, that side then reads 0 and the other side reads 1; the two sides never both read 0.
- R6: A request (write 0) from the non-owner leaves what both sides read unchanged.
- R7: A pending request is granted at the same edge on which the holder writes 1, so the waiter reads 0 afterwards.
- R8: A waiter that writes 1 withdraws its request; a later release by the holder then leaves the token FREE.
- R9: When both sides request a FREE token in the same cycle, left is granted and right is left waiting.
- R10: A legal read loads the port's view of the addressed token onto all data bits at the clock edge ending the read, using the state before any write at that edge; the value holds until the port's next legal read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lft_sem_sel | input | 1 | Left port semaphore select |
| lft_mem_en | input | 1 | Left port memory enable; must be 0 for a semaphore access |
| lft_wr_en | input | 1 | Left port write strobe |
| lft_rd_en | input | 1 | Left port read strobe (ignored when write strobe is set) |
| lft_addr | input | ADDR_W | Left port address; low bits select the token |
| lft_wdata | input | DATA_W | Left port write data; bit 0 used |
| lft_rdata | output | DATA_W | Left port registered read data |
| rgt_sem_sel | input | 1 | Right port semaphore select |
| rgt_mem_en | input | 1 | Right port memory enable; must be 0 for a semaphore access |
| rgt_wr_en | input | 1 | Right port write strobe |
| rgt_rd_en | input | 1 | Right port read strobe (ignored when write strobe is set) |
| rgt_addr | input | ADDR_W | Right port address; low bits select the token |
| rgt_wdata | input | DATA_W | Right port write data; bit 0 used |
| rgt_rdata | output | DATA_W | Right port registered read data |

## Verification
The assertions assume that every port input is synchronous to the clock, held steady through each edge and free of unknown values after reset, and that a port issues at most one access per cycle. The stimulus drives all inputs on the falling edge, drops the strobes one step after the rising edge, and compares read data at the following falling edge. It places the contention cases, simultaneous requests and a read that meets a write from the other side on the same token, in single cycles so that the ordering rules of R9 and R10 are exercised exactly at the edge.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [2:0] {
        TOK_FREE        = 3'd0,
        TOK_LEFT_OWN    = 3'd1,
        TOK_RIGHT_OWN   = 3'd2,
        TOK_LEFT_RWAIT  = 3'd3,
        TOK_RIGHT_LWAIT = 3'd4
    } tok_state_e;

endpackage

// File: rtl/sem_token_fsm.sv
module sem_token_fsm
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_req,
    input  logic l_rel,
    input  logic r_req,
    input  logic r_rel,
    output logic l_view,
    output logic r_view
);

    tok_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TOK_FREE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOK_FREE: begin
                if (l_req)      state_d = r_req ? TOK_LEFT_RWAIT : TOK_LEFT_OWN;
                else if (r_req) state_d = TOK_RIGHT_OWN;
            end
            TOK_LEFT_OWN: begin
                if (l_rel)      state_d = r_req ? TOK_RIGHT_OWN : TOK_FREE;
                else if (r_req) state_d = TOK_LEFT_RWAIT;
            end
            TOK_RIGHT_OWN: begin
                if (r_rel)      state_d = l_req ? TOK_LEFT_OWN : TOK_FREE;
                else if (l_req) state_d = TOK_RIGHT_LWAIT;
            end
            TOK_LEFT_RWAIT: begin
                if (l_rel)      state_d = r_rel ? TOK_FREE : TOK_RIGHT_OWN;
                else if (r_rel) state_d = TOK_LEFT_OWN;
            end
            TOK_RIGHT_LWAIT: begin
                if (r_rel)      state_d = l_rel ? TOK_FREE : TOK_LEFT_OWN;
                else if (l_rel) state_d = TOK_RIGHT_OWN;
            end
            default: state_d = TOK_FREE;
        endcase
    end

    // outputs: 0 means "this side owns the token"
    always_comb begin
        l_view = 1'b1;
        r_view = 1'b1;
        unique case (state_q)
            TOK_LEFT_OWN, TOK_LEFT_RWAIT:   l_view = 1'b0;
            TOK_RIGHT_OWN, TOK_RIGHT_LWAIT: r_view = 1'b0;
            default: ;
        endcase
    end

    AST_VIEW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_view || r_view)); // R5

    AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (l_view && r_view && l_req && r_req) |=> (!l_view && r_view)); // R9

    AST_NONOWNER_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_view && r_req && !l_rel) |=> (!l_view && r_view)); // R6

    AST_HANDOFF_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TOK_LEFT_RWAIT && l_rel && !r_rel) |=> (!r_view && l_view)); // R7

    AST_WITHDRAW_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TOK_LEFT_RWAIT && r_rel && !l_rel) |=> (state_q == TOK_LEFT_OWN)); // R8

endmodule

// File: rtl/sem_port.sv
module sem_port #(
    parameter int NUM_TOK = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16,
    localparam int IDX_W  = $clog2(NUM_TOK)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sem_sel,
    input  logic               mem_en,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [NUM_TOK-1:0] view,
    output logic [NUM_TOK-1:0] req,
    output logic [NUM_TOK-1:0] rel,
    output logic [DATA_W-1:0]  rdata
);

    logic             acc_ok;
    logic             wr_hit;
    logic             rd_hit;
    logic [IDX_W-1:0] idx;
    logic             sel_view;
    logic             unused_hi_bits;

    assign acc_ok = sem_sel & ~mem_en;
    assign wr_hit = acc_ok & wr_en;
    assign rd_hit = acc_ok & rd_en & ~wr_en;
    assign idx    = addr[IDX_W-1:0];

    assign unused_hi_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    for (genvar g = 0; g < NUM_TOK; g++) begin : g_dec
        logic hit;
        assign hit    = wr_hit && (idx == IDX_W'(g));
        assign req[g] = hit && !wdata[0];
        assign rel[g] = hit &&  wdata[0];
    end

    always_comb begin
        sel_view = 1'b1;
        for (int i = 0; i < NUM_TOK; i++) begin
            if (idx == IDX_W'(i)) sel_view = view[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata <= '1;
        else if (rd_hit) rdata <= {DATA_W{sel_view}};
    end

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (sem_sel && mem_en) |-> (req == '0 && rel == '0)); // R3

    AST_ONE_TOKEN_TOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(req | rel) <= 1); // R2

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(sem_sel && !mem_en && rd_en && !wr_en) |=> $stable(rdata)); // R10

    AST_RDATA_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata == '0 || rdata == '1)); // R10

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
    parameter int NUM_TOK = 8,
    parameter int ADDR_W  = 14,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_sem_sel,
    input  logic              lft_mem_en,
    input  logic              lft_wr_en,
    input  logic              lft_rd_en,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic [DATA_W-1:0] lft_wdata,
    output logic [DATA_W-1:0] lft_rdata,
    input  logic              rgt_sem_sel,
    input  logic              rgt_mem_en,
    input  logic              rgt_wr_en,
    input  logic              rgt_rd_en,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic [DATA_W-1:0] rgt_wdata,
    output logic [DATA_W-1:0] rgt_rdata
);

    logic [NUM_TOK-1:0] l_req, l_rel, r_req, r_rel;
    logic [NUM_TOK-1:0] l_view, r_view;

    sem_port #(.NUM_TOK(NUM_TOK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lft (
        .clk(clk), .rst_n(rst_n),
        .sem_sel(lft_sem_sel), .mem_en(lft_mem_en),
        .wr_en(lft_wr_en), .rd_en(lft_rd_en),
        .addr(lft_addr), .wdata(lft_wdata),
        .view(l_view), .req(l_req), .rel(l_rel), .rdata(lft_rdata)
    );

    sem_port #(.NUM_TOK(NUM_TOK), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rgt (
        .clk(clk), .rst_n(rst_n),
        .sem_sel(rgt_sem_sel), .mem_en(rgt_mem_en),
        .wr_en(rgt_wr_en), .rd_en(rgt_rd_en),
        .addr(rgt_addr), .wdata(rgt_wdata),
        .view(r_view), .req(r_req), .rel(r_rel), .rdata(rgt_rdata)
    );

    for (genvar t = 0; t < NUM_TOK; t++) begin : g_tok
        sem_token_fsm u_tok (
            .clk(clk), .rst_n(rst_n),
            .l_req(l_req[t]), .l_rel(l_rel[t]),
            .r_req(r_req[t]), .r_rel(r_rel[t]),
            .l_view(l_view[t]), .r_view(r_view[t])
        );
    end

endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 14;
    localparam int DW = 16;
    localparam int WATCHDOG_CYC = 5000;

    // op codes for the driver
    localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2, OP_BAD_WR = 3, OP_BAD_RD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic          l_sel, l_mem, l_wr, l_rd, r_sel, r_mem, r_wr, r_rd;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wd, r_wd, l_rdata, r_rdata;

    int errors = 0;
    int checks = 0;

    logic [DW-1:0] lq_exp[$], rq_exp[$];
    string         lq_tag[$], rq_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .lft_sem_sel(l_sel), .lft_mem_en(l_mem), .lft_wr_en(l_wr), .lft_rd_en(l_rd),
        .lft_addr(l_addr), .lft_wdata(l_wd), .lft_rdata(l_rdata),
        .rgt_sem_sel(r_sel), .rgt_mem_en(r_mem), .rgt_wr_en(r_wr), .rgt_rd_en(r_rd),
        .rgt_addr(r_addr), .rgt_wdata(r_wd), .rgt_rdata(r_rdata)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_all();
        l_sel = 0; l_mem = 0; l_wr = 0; l_rd = 0; l_addr = '0; l_wd = '0;
        r_sel = 0; r_mem = 0; r_wr = 0; r_rd = 0; r_addr = '0; r_wd = '0;
    endtask

    // one cycle on both ports; expected read bits pushed to the scoreboard
    task automatic cyc(input int lop, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic lexp, input string ltag,
                       input int rop, input logic [AW-1:0] ra, input logic [DW-1:0] rd,
                       input logic rexp, input string rtag);
        @(negedge clk);
        l_sel = (lop != OP_IDLE); l_mem = (lop >= OP_BAD_WR);
        l_wr = (lop == OP_WR || lop == OP_BAD_WR); l_rd = (lop == OP_RD || lop == OP_BAD_RD);
        l_addr = la; l_wd = ld;
        r_sel = (rop != OP_IDLE); r_mem = (rop >= OP_BAD_WR);
        r_wr = (rop == OP_WR || rop == OP_BAD_WR); r_rd = (rop == OP_RD || rop == OP_BAD_RD);
        r_addr = ra; r_wd = rd;
        if (lop == OP_RD) begin lq_exp.push_back({DW{lexp}}); lq_tag.push_back(ltag); end
        if (rop == OP_RD) begin rq_exp.push_back({DW{rexp}}); rq_tag.push_back(rtag); end
        @(posedge clk);
        #1 idle_all();
    endtask

    task automatic lw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cyc(OP_WR, a, d, 1'b0, "", OP_IDLE, '0, '0, 1'b0, "");
    endtask
    task automatic rw(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cyc(OP_IDLE, '0, '0, 1'b0, "", OP_WR, a, d, 1'b0, "");
    endtask
    task automatic rd_both(input logic [AW-1:0] a, input logic le, input logic re, input string tag);
        cyc(OP_RD, a, '0, le, {tag, " left"}, OP_RD, a, '0, re, {tag, " right"});
    endtask

    // monitor: compares registered read data one half cycle after the edge
    initial begin
        forever begin
            logic lf, rf;
            @(posedge clk);
            lf = rst_n && l_sel && !l_mem && l_rd && !l_wr;
            rf = rst_n && r_sel && !r_mem && r_rd && !r_wr;
            @(negedge clk);
            if (lf) begin
                if (lq_exp.size() == 0) check("left read without expectation", l_rdata, 'x);
                else check(lq_tag.pop_front(), l_rdata, lq_exp.pop_front());
            end
            if (rf) begin
                if (rq_exp.size() == 0) check("right read without expectation", r_rdata, 'x);
                else check(rq_tag.pop_front(), r_rdata, rq_exp.pop_front());
            end
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset left rdata", l_rdata, '1);
        check("R1 reset right rdata", r_rdata, '1);
        cyc(OP_RD, 14'd0, '0, 1'b1, "R1 left token0 free", OP_RD, 14'd7, '0, 1'b1, "R1 right token7 free");

        // R2 + R5: left claims token 2 with high address bits set
        lw(14'h2A02, 16'h0000);
        rd_both(14'h0002, 1'b0, 1'b1, "R5 R2 claim token2");
        // R6: right request while left holds
        rw(14'h1F02, 16'h0000);
        rd_both(14'h0002, 1'b0, 1'b1, "R6 nonowner request");
        // R7: left releases, right gets it
        lw(14'h0002, 16'h0001);
        rd_both(14'h0002, 1'b1, 1'b0, "R7 handoff");
        // R4: right releases -> free
        rw(14'h0002, 16'h0001);
        rd_both(14'h0002, 1'b1, 1'b1, "R4 release");

        // R4: only bit 0 matters
        rw(14'h0005, 16'hFFFE);
        rd_both(14'h0005, 1'b1, 1'b0, "R4 request with upper bits set");
        lw(14'h0005, 16'h0001);
        rd_both(14'h0005, 1'b1, 1'b0, "R4 nonowner write 1 no effect");

        // R3: illegal access ignored
        lw(14'h0000, 16'h0000);
        cyc(OP_RD, 14'h0003, '0, 1'b1, "R3 left token3 before", OP_IDLE, '0, '0, 1'b0, "");
        cyc(OP_BAD_WR, 14'h0003, 16'h0000, 1'b0, "", OP_IDLE, '0, '0, 1'b0, "");
        cyc(OP_BAD_RD, 14'h0000, '0, 1'b0, "", OP_IDLE, '0, '0, 1'b0, "");
        @(negedge clk);
        check("R3 illegal read leaves rdata", l_rdata, '1);
        rd_both(14'h0003, 1'b1, 1'b1, "R3 illegal write ignored");

        // R9: simultaneous request on free token 4
        cyc(OP_WR, 14'h0004, 16'h0, 1'b0, "", OP_WR, 14'h0004, 16'h0, 1'b0, "");
        rd_both(14'h0004, 1'b0, 1'b1, "R9 tie left wins");
        lw(14'h0004, 16'h0001);
        rd_both(14'h0004, 1'b1, 1'b0, "R9 right pending granted");

        // R8: withdraw a pending request
        lw(14'h0006, 16'h0000);
        rw(14'h0006, 16'h0000);
        rw(14'h0006, 16'h0001);
        rd_both(14'h0006, 1'b0, 1'b1, "R8 after withdraw");
        lw(14'h0006, 16'h0001);
        rd_both(14'h0006, 1'b1, 1'b1, "R8 free after release");

        // R10: read sees pre-edge state and holds
        lw(14'h0001, 16'h0000);
        cyc(OP_RD, 14'h0001, '0, 1'b0, "R10 left read with concurrent write",
            OP_WR, 14'h0001, 16'h0000, 1'b0, "");
        cyc(OP_WR, 14'h0001, 16'h0001, 1'b0, "",
            OP_RD, 14'h0001, '0, 1'b1, "R10 right read at handoff edge");
        cyc(OP_IDLE, '0, '0, 1'b0, "", OP_RD, 14'h0001, '0, 1'b0, "R10 right read after handoff");
        @(negedge clk);
        check("R10 left rdata held", l_rdata, '0);

        repeat (3) @(negedge clk);
        if (lq_exp.size() != 0 || rq_exp.size() != 0)
            check("scoreboard drained", DW'(lq_exp.size() + rq_exp.size()), '0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule